// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is a watchdog timer run through a single 8-bit control register on a simple bus with an address, a write strobe, a read strobe, write data and read data. Software starts the timer by writing zero to the arm/kick bit. Writing zero to the same bit while the timer runs restarts the count. A two-bit interval code is taken only from the write that starts the timer. After that it stays fixed until the timer stops again.

The counter advances once per cycle in which the prescaled tick-enable input is high. When the selected number of ticks has passed without a kick, the block raises a reset request for one cycle, records a watchdog cause and stops. The same register also holds five sticky cause flags: power-on, hardware standby, watchdog, external pin and software reset. The external reset generator reports standby, pin and software resets as one-cycle event inputs. Any read of the register returns the flags and then clears them.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset (rst_n low) the cause flags are 10000 in field order {power-on, standby, watchdog, external, software}, the register reads 0x87, the timer is stopped and wdt_rst_req is 0.
- R2: A read at REG_ADDR returns the five cause flags in bits 7..3 and ones in bits 2..0, all in the same cycle. bus_rdata is 0 when no read to REG_ADDR is active.
- R3: Every read at REG_ADDR clears all flags at the clock edge that ends the read. A cause event in that same cycle still leaves its flag set.
- R4: Written values of bits 7..3 have no effect on the flags.
- R5: While the timer is stopped, a write with bit 2 = 0 starts it and captures bits 1..0 as the interval code. A write with bit 2 = 1 does nothing.
- R6: The interval for code c is 2^(BASE_EXP+2c) ticks. wdt_rst_req is high for exactly the one cycle after the clock edge that samples the 2^(BASE_EXP+2c)-th tick since the start or last kick.
- R7: While the timer runs, a write with bit 2 = 0 resets the tick count to zero. This wins over a tick in the same cycle. Bits 1..0 of that write are ignored.
- R8: On expiry the watchdog flag (bit 5) is set and the timer stops. No further request comes until the timer is started again.
- R9: standby_evt sets bit 6 and stops the timer. extpin_evt sets bit 4 and swrst_evt sets bit 3, and neither of these disturbs a running timer.
- R10: Reads and writes at any address other than REG_ADDR have no effect and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| tick_en | input | 1 | Prescaled tick, advances the counter |
| standby_evt | input | 1 | Hardware standby reset occurred (one cycle) |
| extpin_evt | input | 1 | External pin reset occurred (one cycle) |
| swrst_evt | input | 1 | Software reset occurred (one cycle) |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The timer is started with each of the four interval codes, with ticks on every cycle. The request position is then compared with the computed tick count, which separates the codes from each other and from an off-by-one expiry. Directed cases cover the following:
- a kick that carries a different code, in the same cycle as a tick, which separates "clear wins" from "tick wins" and shows that the code does not change mid-run;
- a standby event against pin and software events, which shows which causes stop the timer;
- an event during a read, which shows that a set wins over the read clear;
- accesses at a wrong address.

A seeded random phase mixes sparse ticks with random kicks and restarts, and compares every request cycle against a bench model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CAUSE_N = 5;

  typedef struct packed {
    logic por;
    logic stby;
    logic wdt;
    logic ext;
    logic sw;
  } cause_t;

  // number of ticks in the interval chosen by code
  function automatic int unsigned ticks_for(input logic [1:0] code, input int unsigned base);
    return 32'd1 << (base + 32'(2 * int'(code)));
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_EXP = 10,
  parameter int CNT_W    = BASE_EXP + 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_i,
  input  logic       kick_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       expire_o,
  output logic       rst_req_o
);
  import wdog_pkg::*;

  logic             running;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(ticks_for(sel_q, BASE_EXP) - 32'd1);
  assign expire_o = running && tick_i && !kick_i && !stop_i && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      sel_q     <= 2'b00;
      cnt       <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire_o;
      if (stop_i || expire_o) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (kick_i) begin
        if (!running) begin
          running <= 1'b1;
          sel_q   <= sel_i;
        end
        cnt <= '0;
      end else if (running && tick_i) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R6
  AST_REQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !running); // R8
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(sel_q)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= last_cnt)); // R6
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && running && !stop_i) |=> (cnt == '0)); // R7
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_i,
  input  logic       stby_set_i,
  input  logic       wdt_set_i,
  input  logic       ext_set_i,
  input  logic       sw_set_i,
  output logic [7:0] rdata_o
);
  import wdog_pkg::*;

  cause_t flags;
  cause_t set_vec;

  assign set_vec = '{por: 1'b0, stby: stby_set_i, wdt: wdt_set_i, ext: ext_set_i, sw: sw_set_i};
  assign rdata_o = rd_i ? {flags, 3'b111} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '{por: 1'b1, default: 1'b0};
    else        flags <= (rd_i ? cause_t'('0) : flags) | set_vec;
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && set_vec == '0) |=> (flags == '0)); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((flags & $past(flags)) == $past(flags))); // R3
  AST_WDT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_set_i |=> flags.wdt); // R8
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int          ADDR_W   = 8,
  parameter int          BASE_EXP = 10,
  parameter [ADDR_W-1:0] REG_ADDR = ADDR_W'(32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_en,
  input  logic              standby_evt,
  input  logic              extpin_evt,
  input  logic              swrst_evt,
  output logic              wdt_rst_req
);
  localparam int CNT_W = BASE_EXP + 6;

  logic hit;
  logic wr_hit;
  logic rd_hit;
  logic kick;
  logic wdt_expire;
  logic unused_wdata;

  assign hit          = (bus_addr == REG_ADDR);
  assign wr_hit       = bus_wr && hit;
  assign rd_hit       = bus_rd && hit;
  assign kick         = wr_hit && !bus_wdata[2];
  assign unused_wdata = ^bus_wdata[7:3];

  wdog_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (standby_evt),
    .kick_i    (kick),
    .sel_i     (bus_wdata[1:0]),
    .tick_i    (tick_en),
    .expire_o  (wdt_expire),
    .rst_req_o (wdt_rst_req)
  );

  wdog_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (rd_hit),
    .stby_set_i (standby_evt),
    .wdt_set_i  (wdt_expire),
    .ext_set_i  (extpin_evt),
    .sw_set_i   (swrst_evt),
    .rdata_o    (bus_rdata)
  );

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (bus_rdata == 8'h00)); // R10
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int BASE = 4;
  localparam logic [7:0] RA = 8'h20;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0, tick_en = 0;
  logic standby_evt = 0, extpin_evt = 0, swrst_evt = 0, wdt_rst_req;
  int total = 0, bad = 0;
  logic done = 0;

  always #2 clk = ~clk;

  wdog_top #(.ADDR_W(8), .BASE_EXP(BASE), .REG_ADDR(RA)) dut (.*);

  function automatic int lim(input int code);
    return 1 << (BASE + 2 * code);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic t);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1; tick_en = t;
    @(posedge clk); #1 bus_wr = 0; tick_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  // run n ticked cycles, expect request only at position at (0 = never)
  task automatic run(input int n, input int at, input string tag);
    int errs = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk); tick_en = 1;
      @(posedge clk); #1;
      if (wdt_rst_req !== (k == at)) errs++;
    end
    tick_en = 0;
    chk(errs == 0, tag, errs, 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 / R2 reset state and read format
    chk(wdt_rst_req == 0, "R1 req after reset", wdt_rst_req, 0);
    chk(bus_rdata == 0, "R2 idle rdata", bus_rdata, 0);
    rd(RA, v); chk(v == 8'h87, "R1 reset flags", v, 8'h87);
    rd(RA, v); chk(v == 8'h07, "R3 read clears", v, 8'h07);
    // R4 / R5 write with bit2=1 neither sets flags nor arms
    wr(RA, 8'hFC, 0);
    rd(RA, v); chk(v == 8'h07, "R4 flag bits not writable", v, 8'h07);
    run(lim(0) * 3, 0, "R5 write one does not arm");
    // R6 / R8 every interval code
    for (int c = 0; c < 4; c++) begin
      wr(RA, 8'(c), 0);
      run(lim(c) + 8, lim(c), $sformatf("R6 interval code %0d", c));
      run(lim(0) * 2, 0, "R8 stopped after expiry");
      rd(RA, v); chk(v == 8'h27, "R8 watchdog flag", v, 8'h27);
    end
    // R7 kick with other code, same cycle as tick
    wr(RA, 8'h00, 0);
    run(10, 0, "R7 before kick");
    wr(RA, 8'h03, 1);
    run(lim(0) + 4, lim(0), "R7 kick clears, code ignored");
    rd(RA, v); chk(v == 8'h27, "R7 expiry flag", v, 8'h27);
    // R9 standby stops the timer
    wr(RA, 8'h00, 0);
    run(5, 0, "R9 pre-standby");
    @(negedge clk); standby_evt = 1; tick_en = 1;
    @(posedge clk); #1 standby_evt = 0; tick_en = 0;
    run(lim(0) * 3, 0, "R9 standby stops");
    rd(RA, v); chk(v == 8'h47, "R9 standby flag", v, 8'h47);
    // R9 ext and sw do not stop
    begin
      int errs = 0;
      wr(RA, 8'h01, 0);
      for (int k = 1; k <= lim(1) + 4; k++) begin
        @(negedge clk); tick_en = 1; extpin_evt = (k == 3); swrst_evt = (k == 7);
        @(posedge clk); #1;
        if (wdt_rst_req !== (k == lim(1))) errs++;
      end
      tick_en = 0; extpin_evt = 0; swrst_evt = 0;
      chk(errs == 0, "R9 ext/sw keep timer running", errs, 0);
    end
    rd(RA, v); chk(v == 8'h3F, "R9 ext sw wdt flags", v, 8'h3F);
    // R3 event during read survives
    @(negedge clk); bus_addr = RA; bus_rd = 1; extpin_evt = 1; #1 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 0; extpin_evt = 0;
    chk(v == 8'h07, "R3 read value during event", v, 8'h07);
    rd(RA, v); chk(v == 8'h17, "R3 set wins over clear", v, 8'h17);
    // R10 other address
    rd(8'h21, v); chk(v == 8'h00, "R10 miss read", v, 0);
    rd(RA, v); chk(v == 8'h07, "R10 miss read kept flags", v, 8'h07);
    wr(8'h21, 8'h00, 0);
    run(lim(0) * 3, 0, "R10 miss write does not arm");
    // random phase with bench model (R6 R7)
    for (int t = 0; t < 6; t++) begin
      bit run_m = 0; int cnt_m = 0, l_m = 0, errs = 0;
      for (int k = 0; k < 3000; k++) begin
        bit tk, kc, exp_req; logic [1:0] code;
        tk = ($urandom % 3) != 0;
        kc = ($urandom % 80) == 0;
        code = 2'($urandom % 2);
        @(negedge clk); tick_en = tk; bus_addr = RA; bus_wr = kc; bus_wdata = {6'b0, code};
        @(posedge clk);
        exp_req = run_m && tk && !kc && (cnt_m == l_m - 1);
        if (kc) begin
          if (!run_m) begin run_m = 1; l_m = lim(int'(code)); end
          cnt_m = 0;
        end else if (exp_req) begin run_m = 0; cnt_m = 0; end
        else if (run_m && tk) cnt_m++;
        #1;
        if (wdt_rst_req !== exp_req) errs++;
      end
      bus_wr = 0; tick_en = 0;
      chk(errs == 0, "R6 R7 random kicks", errs, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule